// File: doc/BRIEF.md
# Bus Width Translation Access Splitter

This block connects a 64-bit internal request port to a 32-bit external data bus. The region behind the external bus is 16 or 32 bits wide, and the requester states that width with each access. When an internal access is wider than the external port, the block turns it into a short run of narrow external beats. On writes it routes the matching slice of the 64-bit word onto the external data pins for each beat. On reads it collects the returned slices into a 64-bit result. The block raises a lock signal to the external bus arbiter, so no other master can take the bus between the beats of one split access.

Each beat uses a plain request/acknowledge handshake. The block holds a beat's address, direction and data steady until the external side acknowledges it. Only after the final acknowledge does the block return a one-cycle completion pulse and the read result to the internal side. Reset is asynchronous and active-low. It is expected to be released synchronously to `clk` by the reset tree outside the block. Internal accesses are 16, 32 or 64 bits wide. The block does not generate wait states or chip-select timing, and it does not decode addresses to regions.

Top module: `bus_width_splitter`

## Requirements
- R1: On acceptance (`req_valid` high while `req_ready` is high) the block latches the access size (`req_size`: 0 = 16 bits, 1 = 32 bits, 2 or 3 = 64 bits) and the port width (`cfg_port_wide`: 0 = 16-bit region, 1 = 32-bit region). It then issues exactly max(1, size/port) beats. A later change on these inputs has no effect on an access that has already started.
- R2: A 64-bit access to a 16-bit region takes exactly four beats. A 64-bit access to a 32-bit region takes exactly two beats.
- R3: `ext_lock` is high from the first beat of a multi-beat access until its final acknowledge, and low in the cycle after that acknowledge. It is never raised for a single-beat access.
- R4: Beat k drives `ext_addr` = base + k × (port bytes), where base is `req_addr` with its low log2(size bytes) bits cleared. The beats therefore ascend in address.
- R5: On a 32-bit region, a write beat drives all 32 bits of `ext_wdata` with `req_wdata[63:32]` when bit 2 of the beat address is 1, and with `req_wdata[31:0]` when it is 0.
- R6: On a 16-bit region, a write beat drives `ext_wdata[15:0]` with the 16-bit slice of `req_wdata` numbered by beat address bits [2:1] (slice n is bits 16n+15..16n). `ext_wdata[31:16]` is driven to zero.
- R7: On a read, each acknowledged beat stores its data in the 64-bit result. A 16-bit region stores `ext_rdata[15:0]` into slice n (beat address bits [2:1]). A 32-bit region stores `ext_rdata[31:0]` into the half picked by beat address bit 2. Every part of the result that no beat stores reads as zero. After a write, `rsp_rdata` is all zero.
- R8: `ext_req` stays high with stable `ext_addr`, `ext_we` and `ext_wdata` until `ext_ack` is sampled high. Only an acknowledge moves the block to the next beat.
- R9: `rsp_done` pulses for exactly one cycle, in the cycle after the final acknowledge, with `rsp_rdata` valid. In that cycle `req_ready` is high and `ext_req` is low.
- R10: `req_ready` is low while an access is in progress. A `req_valid` raised during that time is ignored: it starts no beat and changes no beat.
- R11: In reset, `req_ready` is 1 and `ext_req`, `ext_lock` and `rsp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Block is idle and can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (0: 16, 1: 32, 2/3: 64 bits) |
| req_addr | input | AW | Internal byte address |
| req_wdata | input | IDW | Internal write data |
| cfg_port_wide | input | 1 | Region port width (0: 16-bit, 1: 32-bit) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | IDW | Assembled read data |
| ext_req | output | 1 | External beat request |
| ext_we | output | 1 | External beat is a write |
| ext_addr | output | AW | External beat byte address |
| ext_wdata | output | EDW | External write data pins |
| ext_rdata | input | EDW | External read data pins |
| ext_ack | input | 1 | External beat acknowledge |
| ext_lock | output | 1 | Hold external bus ownership |

## Verification
The bench sends unaligned addresses. A design that failed to clear the low address bits would start beats mid-word and steer the wrong slices. It covers narrow accesses on the wide port: a 16-bit read there must fill a whole 32-bit half, and a design confusing the two lane selections would fill a single slice. In the middle of a multi-beat access the bench raises a competing request and flips the port width. A design that re-sampled its inputs would change its beat count or accept the second access while still locked. Acknowledges arrive with zero to several cycles of delay, so a design that advanced without an acknowledge, or dropped the lock before the last beat, would be caught.

// File: rtl/bws_pkg.sv
package bws_pkg;

  // Access size codes on the internal side (log2 of bytes, minus one).
  typedef enum logic [1:0] {
    SZ_HALF  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } acc_size_e;

  // Effective size code: the spare code behaves as a 64-bit access.
  function automatic logic [1:0] eff_size(input logic [1:0] sz);
    return (sz == SZ_DWALT) ? SZ_DWORD : sz;
  endfunction

  // log2 of the number of external beats for a size on a port width.
  function automatic logic [1:0] lg_beats(input logic [1:0] sz, input logic wide);
    logic [1:0] s;
    logic [1:0] p;
    s = eff_size(sz);
    p = {1'b0, wide};
    return (s > p) ? (s - p) : 2'd0;
  endfunction

endpackage

// File: rtl/bws_beat_ctrl.sv
module bws_beat_ctrl
  import bws_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BCW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          cfg_port_wide,
  input  logic          ext_ack,
  output logic          req_ready,
  output logic          accept,
  output logic          beat_fire,
  output logic          port_wide,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic          ext_lock,
  output logic          rsp_done
);

  logic           busy_q, busy_d;
  logic [BCW-1:0] beat_q, beat_d;
  logic [BCW-1:0] last_q, last_d;
  logic [AW-1:0]  base_q, base_d;
  logic           wide_q;
  logic           we_q;
  logic           done_q, done_d;
  logic           fin;

  // Next-state logic
  always_comb begin
    logic [1:0] lgb;
    int         lg_size;
    accept    = req_valid && !busy_q;
    beat_fire = busy_q && ext_ack;
    fin       = beat_fire && (beat_q == last_q);

    lgb     = lg_beats(req_size, cfg_port_wide);
    last_d  = BCW'((1 << lgb) - 1);
    lg_size = int'(eff_size(req_size)) + 1;
    for (int i = 0; i < AW; i++) begin
      base_d[i] = (i < lg_size) ? 1'b0 : req_addr[i];
    end

    busy_d = busy_q;
    beat_d = beat_q;
    if (accept) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (beat_fire) begin
      beat_d = beat_q + BCW'(1);
    end
    done_d = fin;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      done_q <= done_d;
    end
  end

  // Access descriptor, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      base_q <= '0;
      wide_q <= 1'b0;
      we_q   <= 1'b0;
    end else if (accept) begin
      last_q <= last_d;
      base_q <= base_d;
      wide_q <= cfg_port_wide;
      we_q   <= req_write;
    end
  end

  assign req_ready = !busy_q;
  assign ext_req   = busy_q;
  assign ext_we    = we_q;
  assign ext_lock  = busy_q && (last_q != '0);
  assign rsp_done  = done_q;
  assign port_wide = wide_q;
  assign ext_addr  = base_q + (AW'(beat_q) << (wide_q ? 2 : 1));

endmodule

// File: rtl/bws_lane_mux.sv
module bws_lane_mux #(
  parameter int IDW = 64,
  parameter int EDW = 32,
  parameter int I16W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            beat_fire,
  input  logic            port_wide,
  input  logic            beat_we,
  input  logic [I16W-1:0] lane_idx,
  input  logic [IDW-1:0]  req_wdata,
  input  logic [EDW-1:0]  ext_rdata,
  output logic [EDW-1:0]  ext_wdata,
  output logic [IDW-1:0]  rsp_rdata
);

  localparam int NL16 = IDW / 16;
  localparam int NL32 = IDW / 32;
  localparam int I32W = I16W - 1;

  logic [IDW-1:0]  wdata_q;
  logic [15:0]     w16 [NL16];
  logic [31:0]     w32 [NL32];
  logic [I32W-1:0] half_idx;

  assign half_idx = lane_idx[I16W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata;
  end

  // Write steering
  for (genvar g = 0; g < NL16; g++) begin : g_w16
    assign w16[g] = wdata_q[g*16 +: 16];
  end
  for (genvar g = 0; g < NL32; g++) begin : g_w32
    assign w32[g] = wdata_q[g*32 +: 32];
  end

  assign ext_wdata = port_wide ? EDW'(w32[half_idx]) : EDW'(w16[lane_idx]);

  // Read assembly, one 16-bit lane per generate step
  for (genvar g = 0; g < NL16; g++) begin : g_asm
    logic [15:0] lane_q, lane_d;
    logic        hit;
    always_comb begin
      hit = port_wide ? (half_idx == I32W'(g / 2)) : (lane_idx == I16W'(g));
      lane_d = lane_q;
      if (accept)
        lane_d = '0;
      else if (beat_fire && !beat_we && hit)
        lane_d = port_wide ? ext_rdata[(g % 2)*16 +: 16] : ext_rdata[15:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end
    assign rsp_rdata[g*16 +: 16] = lane_q;
  end

endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
  parameter int AW  = 32,
  parameter int IDW = 64,
  parameter int EDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_size,
  input  logic [AW-1:0]  req_addr,
  input  logic [IDW-1:0] req_wdata,
  input  logic           cfg_port_wide,
  output logic           rsp_done,
  output logic [IDW-1:0] rsp_rdata,
  output logic           ext_req,
  output logic           ext_we,
  output logic [AW-1:0]  ext_addr,
  output logic [EDW-1:0] ext_wdata,
  input  logic [EDW-1:0] ext_rdata,
  input  logic           ext_ack,
  output logic           ext_lock
);

  localparam int LIDX = $clog2(IDW / 8);
  localparam int I16W = LIDX - 1;
  localparam int BCW  = $clog2(IDW / 16);

  logic accept;
  logic beat_fire;
  logic port_wide;

  bws_beat_ctrl #(
    .AW  (AW),
    .BCW (BCW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_size      (req_size),
    .req_addr      (req_addr),
    .cfg_port_wide (cfg_port_wide),
    .ext_ack       (ext_ack),
    .req_ready     (req_ready),
    .accept        (accept),
    .beat_fire     (beat_fire),
    .port_wide     (port_wide),
    .ext_req       (ext_req),
    .ext_we        (ext_we),
    .ext_addr      (ext_addr),
    .ext_lock      (ext_lock),
    .rsp_done      (rsp_done)
  );

  bws_lane_mux #(
    .IDW  (IDW),
    .EDW  (EDW),
    .I16W (I16W)
  ) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .beat_fire (beat_fire),
    .port_wide (port_wide),
    .beat_we   (ext_we),
    .lane_idx  (ext_addr[LIDX-1:1]),
    .req_wdata (req_wdata),
    .ext_rdata (ext_rdata),
    .ext_wdata (ext_wdata),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int AW  = 32,
  parameter int EDW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_done,
  input logic           ext_req,
  input logic           ext_we,
  input logic [AW-1:0]  ext_addr,
  input logic [EDW-1:0] ext_wdata,
  input logic           ext_ack,
  input logic           ext_lock
);

  // R3: once raised, the lock only drops with the completion pulse
  p_lock_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_lock |=> (ext_lock || rsp_done));

  // R3: an unlocked acknowledged beat is the whole access
  p_single_nolock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack && !ext_lock) |=> rsp_done);

  // R3: lock only accompanies an outstanding beat
  p_lock_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_lock |-> ext_req);

  // R8: an unacknowledged beat is held unchanged
  p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                               && $stable(ext_wdata)));

  // R4: locked beats step upward in address
  p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack && ext_lock) |=> (!ext_lock || (ext_addr > $past(ext_addr))));

  // R9: completion is a single-cycle pulse seen while idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && !ext_req));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10: an idle block drives no beat and no lock
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ext_req && !ext_lock));

endmodule

bind bus_width_splitter bws_checker #(
  .AW  (AW),
  .EDW (EDW)
) u_bws_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .ext_req   (ext_req),
  .ext_we    (ext_we),
  .ext_addr  (ext_addr),
  .ext_wdata (ext_wdata),
  .ext_ack   (ext_ack),
  .ext_lock  (ext_lock)
);

// File: tb/test_bus_width_splitter.sv
`timescale 1ns/1ps
module test_bus_width_splitter;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        cfg_port_wide;
  logic        rsp_done;
  logic [63:0] rsp_rdata;
  logic        ext_req;
  logic        ext_we;
  logic [31:0] ext_addr;
  logic [31:0] ext_wdata;
  logic [31:0] ext_rdata;
  logic        ext_ack;
  logic        ext_lock;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  bus_width_splitter i_bus_width_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_port_wide(cfg_port_wide), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack), .ext_lock(ext_lock)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] resp(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h5A3C};
  endfunction

  // One access from acceptance to the cycle after completion; the
  // reference model builds the expected beat list and result on its own.
  task automatic run(input bit wr, input logic [1:0] sz, input bit pt,
                     input logic [31:0] ad, input logic [63:0] wd,
                     input int dly, input bit mis);
    int s, nb, pb;
    logic [31:0] base, ba, ew;
    logic [63:0] exp, sh;
    s    = (sz == 2'd3) ? 2 : int'(sz);
    pb   = pt ? 4 : 2;
    nb   = (s > int'(pt)) ? (1 << (s - int'(pt))) : 1;
    base = ad & ~((32'd1 << (s + 1)) - 32'd1);
    exp  = '0;
    chk(req_ready === 1'b1, "R10 ready before access", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad;
    req_wdata = wd; cfg_port_wide = pt; ext_ack = 1'b0;
    @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      ba = base + 32'(k * pb);
      for (int w = 0; ; w++) begin
        req_valid = 1'b0;
        cfg_port_wide = pt;
        chk(ext_req === 1'b1, "R8 beat request held", 64'(ext_req), 64'd1);
        chk(ext_addr === ba, "R4 beat address", 64'(ext_addr), 64'(ba));
        chk(ext_we === wr, "R8 beat direction", 64'(ext_we), 64'(wr));
        chk(ext_lock === (nb > 1), "R3 lock level", 64'(ext_lock), 64'(nb > 1));
        chk(req_ready === 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
        chk(rsp_done === 1'b0, "R9 no early done", 64'(rsp_done), 64'd0);
        if (wr) begin
          if (pt) begin
            sh = wd >> (32 * int'(ba[2]));
            ew = sh[31:0];
            chk(ext_wdata === ew, "R5 wide write lanes", 64'(ext_wdata), 64'(ew));
          end else begin
            sh = wd >> (16 * int'(ba[2:1]));
            ew = {16'h0, sh[15:0]};
            chk(ext_wdata === ew, "R6 narrow write slice", 64'(ext_wdata), 64'(ew));
          end
        end
        if (mis && k == 1 && w == 0) begin
          // R10 / R1: competing request and width flip mid-access
          req_valid = 1'b1; req_addr = 32'hFFFF_FFF0; req_size = 2'd0;
          req_write = ~wr; cfg_port_wide = ~pt;
        end
        if (w >= dly) begin
          ext_ack = 1'b1;
          ext_rdata = resp(ba);
          if (!wr) begin
            if (pt) exp[32*int'(ba[2]) +: 32] = resp(ba);
            else    exp[16*int'(ba[2:1]) +: 16] = resp(ba)[15:0];
          end
          @(negedge clk);
          ext_ack = 1'b0;
          ext_rdata = 32'hDEAD_BEEF;
          break;
        end
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    cfg_port_wide = pt;
    chk(rsp_done === 1'b1, "R1/R2 done after expected beat count", 64'(rsp_done), 64'd1);
    chk(req_ready === 1'b1, "R9 ready with done", 64'(req_ready), 64'd1);
    chk(ext_req === 1'b0, "R9 no beat with done", 64'(ext_req), 64'd0);
    chk(ext_lock === 1'b0, "R3 lock released", 64'(ext_lock), 64'd0);
    chk(rsp_rdata === exp, "R7 assembled read data", rsp_rdata, exp);
    @(negedge clk);
    chk(rsp_done === 1'b0, "R9 done is one cycle", 64'(rsp_done), 64'd0);
    chk(ext_req === 1'b0, "R10 ignored request started nothing", 64'(ext_req), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; cfg_port_wide = 1'b0; ext_rdata = '0;
    ext_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
    chk(ext_req === 1'b0, "R11 reset request", 64'(ext_req), 64'd0);
    chk(ext_lock === 1'b0, "R11 reset lock", 64'(ext_lock), 64'd0);
    chk(rsp_done === 1'b0, "R11 reset done", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: 64-bit on 16-bit port, four beats; on 32-bit port, two beats
    run(1, 2'd2, 0, 32'h0000_1000, 64'h1122_3344_5566_7788, 0, 0);
    run(0, 2'd2, 0, 32'h0000_2000, '0, 2, 0);
    run(1, 2'd2, 1, 32'h0000_3008, 64'hA1B2_C3D4_E5F6_0718, 1, 0);
    run(0, 2'd2, 1, 32'h0000_4010, '0, 0, 0);
    // R4: unaligned 64-bit address clears low bits
    run(0, 2'd3, 0, 32'h0000_5007, '0, 1, 0);
    // R6 / R7: 32-bit access on 16-bit port at upper word
    run(1, 2'd1, 0, 32'h0000_6006, 64'hCAFE_F00D_0BAD_BEEF, 0, 0);
    run(0, 2'd1, 0, 32'h0000_6004, '0, 1, 0);
    // R3 / R5: single-beat accesses, no lock
    run(1, 2'd1, 1, 32'h0000_7004, 64'h0123_4567_89AB_CDEF, 0, 0);
    run(0, 2'd0, 1, 32'h0000_7006, '0, 2, 0);
    run(0, 2'd0, 0, 32'h0000_7002, '0, 0, 0);
    run(1, 2'd0, 0, 32'h0000_7004, 64'hFEDC_BA98_7654_3210, 1, 0);
    // R1 / R10: interfering request and port flip mid-sequence
    run(0, 2'd2, 0, 32'h0000_8000, '0, 2, 1);
    run(1, 2'd2, 1, 32'h0000_9000, 64'h5555_AAAA_3333_CCCC, 1, 1);

    for (int i = 0; i < 80; i++) begin
      run(bit'($urandom % 2), 2'($urandom % 4), bit'($urandom % 2), $urandom,
          {$urandom, $urandom}, int'($urandom % 3), bit'($urandom % 4 == 0));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule